// File: doc/BRIEF.md
# Doorbell Request Slot Dispatcher

This block keeps the pending-request state of a storage host controller with two request lists: up to 32 transfer slots and up to 8 task-management slots. Software starts a request by writing a word into the doorbell of a list, with a 1 in the bit of each slot it wants to start. The block remembers the order in which slots were placed. It offers one slot per cycle to a downstream executor over a valid/ready handshake. Task-management work always goes ahead of transfer work.

The executor reports finished slots by list and tag, in any order. Each accepted report clears the slot's doorbell bit. It also raises a one-cycle completion pulse carrying the list and the tag, which the interrupt logic uses. A report that names a slot not currently with the executor is dropped, and a sticky error flag is set.

Top module: `doorbell_dispatch`

## Requirements
- R1: After reset both doorbells read 0, no dispatch is offered, no completion pulse is raised and the error flag is 0.
- R2: A write with `wr_list_i`=0 targets the transfer doorbell and uses all 32 data bits. A write with `wr_list_i`=1 targets the task doorbell and uses data bits [7:0]. A 1 sets the matching doorbell bit. A 0 leaves the bit as it is, and the other list is not touched.
- R3: Within one list, slots are dispatched in the order their doorbell bits went from 0 to 1. Slots set by the same write are dispatched in ascending slot number.
- R4: While any task slot is waiting, the offer is a task slot (`disp_list_o`=1). A transfer slot (`disp_list_o`=0) is offered only when no task slot is waiting.
- R5: Writing 1 to a doorbell bit that is already 1 is ignored. Each placement is dispatched exactly once, and a dispatched slot is not offered again before it completes.
- R6: A completion for a dispatched slot clears its doorbell bit, in any order across slots. In the next cycle `done_valid_o` is high for exactly one cycle, with `done_list_o` and `done_tag_o` naming that slot.
- R7: A completion that names a slot not currently dispatched is ignored. This covers a slot whose doorbell bit is 0 and a slot that is still waiting. It produces no pulse, changes no doorbell, and sets `cpl_err_o`, which stays 1 until reset.
- R8: When a write and a completion fall in the same cycle, both take effect. If both hit the same slot, the doorbell bit ends at 0 and the slot is not queued again.
- R9: `disp_valid_o` is high exactly when some slot is waiting. While `disp_ready_i` is low the offer is held, and a slot leaves the queue only on a cycle with both valid and ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Doorbell write strobe |
| wr_list_i | input | 1 | Write target: 0 transfer, 1 task |
| wr_data_i | input | 32 | Doorbell write data, one bit per slot |
| disp_valid_o | output | 1 | A slot is offered to the executor |
| disp_ready_i | input | 1 | Executor accepts the offer |
| disp_list_o | output | 1 | List of the offered slot |
| disp_tag_o | output | 5 | Slot number of the offered slot |
| cpl_valid_i | input | 1 | Executor reports a finished slot |
| cpl_list_i | input | 1 | List of the finished slot |
| cpl_tag_i | input | 5 | Slot number of the finished slot |
| done_valid_o | output | 1 | One-cycle completion pulse |
| done_list_o | output | 1 | List of the completed slot |
| done_tag_o | output | 5 | Slot number of the completed slot |
| xfer_db_o | output | 32 | Transfer doorbell state |
| task_db_o | output | 8 | Task doorbell state |
| cpl_err_o | output | 1 | Sticky flag for a completion that named no dispatched slot |

## Verification
A doorbell write and a completion can land in the same cycle. The bench provokes this by driving both on the same edge. The completion names an in-flight transfer slot, and the write sets that same slot again together with a fresh one. The result is judged at the ports. The old slot's bit must read 0 and the fresh bit 1, the pulse must name the old slot, and only the fresh slot may be offered afterwards before the offer drops.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
   typedef enum logic {
      LIST_XFER = 1'b0,
      LIST_TASK = 1'b1
   } list_e;
endpackage

// File: rtl/dbd_list.sv
module dbd_list #(
   parameter int N_SLOT = 32,
   localparam int TW = $clog2(N_SLOT),
   localparam int PW = TW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SLOT-1:0] set_i,
   input  logic              pop_i,
   input  logic              cpl_i,
   input  logic [TW-1:0]     cpl_tag_i,
   output logic              cpl_ok_o,
   output logic [N_SLOT-1:0] db_o,
   output logic              head_valid_o,
   output logic [TW-1:0]     head_tag_o
);
   if (N_SLOT < 2 || (N_SLOT & (N_SLOT - 1)) != 0) begin : g_bad_depth
      $error("dbd_list: N_SLOT must be a power of two, at least 2");
   end

   logic [N_SLOT-1:0] db_q, infl_q, fresh, cpl_mask, pop_mask;
   logic [TW-1:0]     ord_q [N_SLOT];
   logic [TW-1:0]     rank  [N_SLOT];
   logic [PW-1:0]     cnt_q, n_push;
   logic [TW-1:0]     rd_q, wr_q;
   logic              pop, hit;

   // only 0->1 transitions are placements; bits already set are ignored
   assign fresh = set_i & ~db_q;

   always_comb begin
      logic [PW-1:0] acc;
      acc = '0;
      for (int i = 0; i < N_SLOT; i++) begin
         rank[i] = acc[TW-1:0];
         acc     = acc + PW'(fresh[i]);
      end
      n_push = acc;
   end

   assign head_valid_o = (cnt_q != '0);
   assign head_tag_o   = ord_q[rd_q];
   assign pop          = pop_i && head_valid_o;
   assign hit          = cpl_i && infl_q[cpl_tag_i];
   assign cpl_ok_o     = infl_q[cpl_tag_i];
   assign cpl_mask     = hit ? (N_SLOT'(1) << cpl_tag_i) : '0;
   assign pop_mask     = pop ? (N_SLOT'(1) << head_tag_o) : '0;
   assign db_o         = db_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         db_q   <= '0;
         infl_q <= '0;
         cnt_q  <= '0;
         rd_q   <= '0;
         wr_q   <= '0;
      end else begin
         db_q   <= (db_q | fresh) & ~cpl_mask;
         infl_q <= (infl_q | pop_mask) & ~cpl_mask;
         cnt_q  <= cnt_q + n_push - PW'(pop);
         wr_q   <= wr_q + n_push[TW-1:0];
         if (pop) rd_q <= rd_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < N_SLOT; i++) begin
         if (fresh[i]) ord_q[TW'(wr_q + rank[i])] <= TW'(i);
      end
   end

   // R5: the queue never holds more entries than there are slots
   assert_queue_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= PW'(N_SLOT));
   // R5: a slot handed out is still rung and was not already with the executor
   assert_pop_fresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (db_q[head_tag_o] && !infl_q[head_tag_o]));
   // R6: a slot with the executor always has its doorbell bit set
   assert_infl_in_db_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (infl_q & ~db_q) == '0);
endmodule

// File: rtl/dbd_pick.sv
module dbd_pick #(
   parameter int TWX = 5,
   parameter int TWT = 3
) (
   input  logic           t_valid_i,
   input  logic [TWT-1:0] t_tag_i,
   input  logic           x_valid_i,
   input  logic [TWX-1:0] x_tag_i,
   input  logic           ready_i,
   output logic           valid_o,
   output logic           list_o,
   output logic [TWX-1:0] tag_o,
   output logic           t_pop_o,
   output logic           x_pop_o
);
   import dbd_pkg::*;
   assign valid_o = t_valid_i | x_valid_i;
   assign list_o  = t_valid_i ? LIST_TASK : LIST_XFER;
   assign tag_o   = t_valid_i ? TWX'(t_tag_i) : x_tag_i;
   assign t_pop_o = ready_i && t_valid_i;
   assign x_pop_o = ready_i && x_valid_i && !t_valid_i;
endmodule

// File: rtl/doorbell_dispatch.sv
module doorbell_dispatch #(
   parameter int N_XFER = 32,
   parameter int N_TASK = 8,
   localparam int TWX = $clog2(N_XFER),
   localparam int TWT = $clog2(N_TASK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              wr_list_i,
   input  logic [N_XFER-1:0] wr_data_i,
   output logic              disp_valid_o,
   input  logic              disp_ready_i,
   output logic              disp_list_o,
   output logic [TWX-1:0]    disp_tag_o,
   input  logic              cpl_valid_i,
   input  logic              cpl_list_i,
   input  logic [TWX-1:0]    cpl_tag_i,
   output logic              done_valid_o,
   output logic              done_list_o,
   output logic [TWX-1:0]    done_tag_o,
   output logic [N_XFER-1:0] xfer_db_o,
   output logic [N_TASK-1:0] task_db_o,
   output logic              cpl_err_o
);
   import dbd_pkg::*;

   if (N_TASK > N_XFER) begin : g_bad_sizes
      $error("doorbell_dispatch: N_TASK must not exceed N_XFER");
   end

   logic              x_hv, t_hv, x_pop, t_pop, x_ok, t_ok, t_tag_fits, cpl_ok;
   logic [TWX-1:0]    x_head;
   logic [TWT-1:0]    t_head;
   logic [N_XFER-1:0] x_set;
   logic [N_TASK-1:0] t_set;
   logic              x_cpl, t_cpl;
   logic              done_q, done_list_q, err_q;
   logic [TWX-1:0]    done_tag_q;

   assign x_set = (wr_en_i && wr_list_i == LIST_XFER) ? wr_data_i : '0;
   assign t_set = (wr_en_i && wr_list_i == LIST_TASK) ? wr_data_i[N_TASK-1:0] : '0;

   if (N_TASK < N_XFER) begin : g_tag_range
      assign t_tag_fits = (cpl_tag_i[TWX-1:TWT] == '0);
   end else begin : g_tag_full
      assign t_tag_fits = 1'b1;
   end

   assign x_cpl  = cpl_valid_i && cpl_list_i == LIST_XFER;
   assign t_cpl  = cpl_valid_i && cpl_list_i == LIST_TASK && t_tag_fits;
   assign cpl_ok = (cpl_list_i == LIST_XFER) ? x_ok : (t_tag_fits && t_ok);

   dbd_list #(.N_SLOT(N_XFER)) u_xfer (
      .clk, .rst_n, .set_i(x_set), .pop_i(x_pop), .cpl_i(x_cpl),
      .cpl_tag_i(cpl_tag_i), .cpl_ok_o(x_ok), .db_o(xfer_db_o),
      .head_valid_o(x_hv), .head_tag_o(x_head));

   dbd_list #(.N_SLOT(N_TASK)) u_task (
      .clk, .rst_n, .set_i(t_set), .pop_i(t_pop), .cpl_i(t_cpl),
      .cpl_tag_i(cpl_tag_i[TWT-1:0]), .cpl_ok_o(t_ok), .db_o(task_db_o),
      .head_valid_o(t_hv), .head_tag_o(t_head));

   dbd_pick #(.TWX(TWX), .TWT(TWT)) u_pick (
      .t_valid_i(t_hv), .t_tag_i(t_head), .x_valid_i(x_hv), .x_tag_i(x_head),
      .ready_i(disp_ready_i), .valid_o(disp_valid_o), .list_o(disp_list_o),
      .tag_o(disp_tag_o), .t_pop_o(t_pop), .x_pop_o(x_pop));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q      <= 1'b0;
         done_list_q <= 1'b0;
         done_tag_q  <= '0;
         err_q       <= 1'b0;
      end else begin
         done_q      <= cpl_valid_i && cpl_ok;
         done_list_q <= cpl_list_i;
         done_tag_q  <= cpl_tag_i;
         if (cpl_valid_i && !cpl_ok) err_q <= 1'b1;
      end
   end

   assign done_valid_o = done_q;
   assign done_list_o  = done_list_q;
   assign done_tag_o   = done_tag_q;
   assign cpl_err_o    = err_q;

   // R6: a pulse only follows a completion report
   assert_pulse_follows_cpl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid_o |-> $past(cpl_valid_i));
   // R7: the error flag never falls once set
   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_err_o |=> cpl_err_o);
   // R4: a transfer offer implies no task slot is rung without being with the executor
   assert_task_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid_o && disp_list_o == LIST_XFER) |-> !t_hv);
   // R9: an offer not taken stays the same in the next cycle unless a new task arrives
   assert_offer_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid_o && !disp_ready_i && !wr_en_i) |=> (disp_valid_o && $stable(disp_tag_o)));
endmodule

// File: tb/doorbell_dispatch_tb_top.sv
module doorbell_dispatch_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_list = 1'b0;
   logic [31:0] wr_data = '0;
   logic        disp_valid, disp_ready = 1'b0, disp_list;
   logic [4:0]  disp_tag;
   logic        cpl_valid = 1'b0, cpl_list = 1'b0;
   logic [4:0]  cpl_tag = '0;
   logic        done_valid, done_list;
   logic [4:0]  done_tag;
   logic [31:0] xfer_db;
   logic [7:0]  task_db;
   logic        cpl_err;
   int          n_cmp = 0, n_bad = 0;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   doorbell_dispatch dut_i (
      .clk, .rst_n, .wr_en_i(wr_en), .wr_list_i(wr_list), .wr_data_i(wr_data),
      .disp_valid_o(disp_valid), .disp_ready_i(disp_ready), .disp_list_o(disp_list),
      .disp_tag_o(disp_tag), .cpl_valid_i(cpl_valid), .cpl_list_i(cpl_list),
      .cpl_tag_i(cpl_tag), .done_valid_o(done_valid), .done_list_o(done_list),
      .done_tag_o(done_tag), .xfer_db_o(xfer_db), .task_db_o(task_db), .cpl_err_o(cpl_err));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ring(input logic lst, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_list = lst; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic take(input logic lst, input logic [4:0] tag, input string req);
      @(negedge clk);
      chk(disp_valid === 1'b1, req, {31'd0, disp_valid}, 32'd1);
      chk(disp_list === lst, req, {31'd0, disp_list}, {31'd0, lst});
      chk(disp_tag === tag, req, {27'd0, disp_tag}, {27'd0, tag});
      disp_ready = 1'b1;
      @(negedge clk);
      disp_ready = 1'b0;
   endtask

   task automatic finish_slot(input logic lst, input logic [4:0] tag, input bit good, input string req);
      @(negedge clk);
      cpl_valid = 1'b1; cpl_list = lst; cpl_tag = tag;
      @(posedge clk); #1;
      chk(done_valid === good, req, {31'd0, done_valid}, {31'd0, good});
      if (good) begin
         chk(done_list === lst && done_tag === tag, req, {26'd0, done_list, done_tag}, {26'd0, lst, tag});
         if (lst) chk(task_db[tag[2:0]] === 1'b0, req, {24'd0, task_db}, 32'd0);
         else     chk(xfer_db[tag] === 1'b0, req, xfer_db, 32'd0);
      end
      @(negedge clk);
      cpl_valid = 1'b0;
      @(posedge clk); #1;
      chk(done_valid === 1'b0, req, {31'd0, done_valid}, 32'd0);
   endtask

   task automatic t_reset;
      chk(xfer_db === 32'd0 && task_db === 8'd0, "R1", xfer_db, 32'd0);
      chk(disp_valid === 1'b0, "R1", {31'd0, disp_valid}, 32'd0);
      chk(done_valid === 1'b0 && cpl_err === 1'b0, "R1", {30'd0, done_valid, cpl_err}, 32'd0);
   endtask

   task automatic t_order;
      ring(1'b0, 32'h0000_0090);
      ring(1'b0, 32'h0000_0011); // bit 4 again is ignored (R5), bit 0 new
      chk(xfer_db === 32'h91, "R2", xfer_db, 32'h91);
      chk(task_db === 8'h00, "R2 other list", {24'd0, task_db}, 32'd0);
      @(negedge clk);
      chk(disp_valid && disp_tag === 5'd4, "R9 held", {27'd0, disp_tag}, 32'd4);
      take(1'b0, 5'd4, "R3");
      take(1'b0, 5'd7, "R3");
      take(1'b0, 5'd0, "R5");
      @(negedge clk);
      chk(disp_valid === 1'b0, "R9 empty", {31'd0, disp_valid}, 32'd0);
   endtask

   task automatic t_task_first;
      ring(1'b0, 32'h0000_0004);
      ring(1'b1, 32'hFFFF_FF22); // only bits [7:0] count: slots 1 and 5
      chk(task_db === 8'h22, "R2 task", {24'd0, task_db}, 32'h22);
      chk(xfer_db === 32'h95, "R2", xfer_db, 32'h95);
      take(1'b1, 5'd1, "R4");
      take(1'b1, 5'd5, "R4");
      take(1'b0, 5'd2, "R4");
   endtask

   task automatic t_complete;
      finish_slot(1'b0, 5'd7, 1'b1, "R6");
      finish_slot(1'b1, 5'd5, 1'b1, "R6");
      finish_slot(1'b0, 5'd0, 1'b1, "R6");
      finish_slot(1'b0, 5'd4, 1'b1, "R6");
      finish_slot(1'b1, 5'd1, 1'b1, "R6");
      finish_slot(1'b0, 5'd2, 1'b1, "R6");
      chk(xfer_db === 32'd0 && task_db === 8'd0, "R6", xfer_db, 32'd0);
      chk(cpl_err === 1'b0, "R6 no err", {31'd0, cpl_err}, 32'd0);
   endtask

   task automatic t_bad;
      finish_slot(1'b0, 5'd9, 1'b0, "R7");
      chk(cpl_err === 1'b1, "R7", {31'd0, cpl_err}, 32'd1);
      ring(1'b0, 32'h0000_0008);
      finish_slot(1'b0, 5'd3, 1'b0, "R7 waiting");
      chk(xfer_db === 32'h8, "R7", xfer_db, 32'h8);
      take(1'b0, 5'd3, "R7");
      chk(cpl_err === 1'b1, "R7 sticky", {31'd0, cpl_err}, 32'd1);
   endtask

   task automatic t_collide;
      @(negedge clk);
      cpl_valid = 1'b1; cpl_list = 1'b0; cpl_tag = 5'd3;
      wr_en = 1'b1; wr_list = 1'b0; wr_data = 32'h0000_0108;
      @(posedge clk); #1;
      chk(done_valid === 1'b1 && done_tag === 5'd3, "R8", {27'd0, done_tag}, 32'd3);
      chk(xfer_db === 32'h100, "R8", xfer_db, 32'h100);
      @(negedge clk);
      cpl_valid = 1'b0; wr_en = 1'b0; wr_data = '0;
      take(1'b0, 5'd8, "R8");
      @(negedge clk);
      chk(disp_valid === 1'b0, "R8 no requeue", {31'd0, disp_valid}, 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order();
      t_task_first();
      t_complete();
      t_bad();
      t_collide();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule